// File: doc/BRIEF.md
# Panel Self-Refresh State Sequencer

This block is a per-pipe controller for a display link's panel self-refresh. It takes control bits as plain register inputs: an enable, a mode field, an active-entry request and a single-frame-update request. From these it steps through six numbered states. Some steps happen only when software writes a control bit. Others the block takes by itself: the static-frame send ends after a set number of frame-start pulses, and the exit ends once the sink has been woken.

The wake-up to the sink goes out over a valid/ready style handshake. `wake_req` acts as valid and `wake_ack` as ready. While `wake_req` is high, the block holds the request and its address/data payload steady until `wake_ack` arrives. It never withdraws the request unless control disables the block. The link transport behind the handshake is outside this block.

Status outputs report:
- the current state,
- an in-transition flag, which control should find clear before disabling,
- a self-refresh-active flag,
- whether a single-frame update is pending.

Top module: `selfrefresh_sequencer`

## Requirements
- R1: A synchronous active-high reset puts the block in state 0 with `wake_req` low, `in_trans` low, `sr_active` low and the single-frame-update flag cleared.
- R2: From state 0 the block moves to state 1 only when `ctl_enable` is high and `ctl_mode` is nonzero. In state 0, `ctl_entry` and `ctl_sfu_set` have no effect and the single-frame-update flag stays cleared.
- R3: In state 1, a high `ctl_entry` moves the block to state 2 at the next clock edge. `frame_start` has no effect in state 1.
- R4: State 2 ends by itself. The edge that samples the STATIC_FRAMES-th `frame_start` pulse counted in state 2 moves the block to state 3, with no further control change.
- R5: In state 3, a low `ctl_entry` moves the block to state 5 at the next edge, never through state 4. This takes priority over a pending single-frame update.
- R6: A pulse on `ctl_sfu_set` outside state 0 sets the pending flag, and the flag stays set until it is consumed. In state 3, with the flag set and `ctl_entry` high, the block moves to state 4. State 4 holds, whatever `ctl_entry` is, until a `frame_start` pulse returns it to state 3. That same edge clears the flag.
- R7: In state 5, `wake_req` is high with `wake_addr` = 0x00600 and `wake_data` = 0x01, both held stable until `wake_ack`. The edge where `wake_req` and `wake_ack` are both high moves the block to state 1. `wake_ack` has no effect in other states.
- R8: When `ctl_enable`, `ctl_mode` and `ctl_entry` are all low, the block enters state 0 at the next edge from any state and clears the pending flag. Clearing only some of the three does not disable the block.
- R9: `state_o` is encoded as follows. `in_trans` is high exactly in states 2 and 5, and `sr_active` is high exactly in states 3 and 4.

| Code | State |
|------|-------|
| 0 | off |
| 1 | inactive |
| 2 | entering with static frame |
| 3 | active, no frame-buffer update |
| 4 | active, single-frame update |
| 5 | exiting |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Enable control bit |
| ctl_mode | input | MODE_W | Mode selection; nonzero required to leave state 0 |
| ctl_entry | input | 1 | Active-entry request bit |
| ctl_sfu_set | input | 1 | Single-frame-update request pulse |
| frame_start | input | 1 | One-cycle pulse at each frame start |
| wake_ack | input | 1 | Ready for the sink wake-up write |
| wake_req | output | 1 | Valid for the sink wake-up write |
| wake_addr | output | ADDR_W | Sink configuration address of the wake-up write |
| wake_data | output | DATA_W | Value of the wake-up write |
| state_o | output | 3 | Current state code |
| in_trans | output | 1 | State is in transition |
| sr_active | output | 1 | Self-refresh active |
| sfu_pending | output | 1 | Single-frame update pending |

## Verification
The bench targets the following corner cases:
- An exit while a single-frame update is pending. A design that ranked the update above the exit would go to state 4 rather than 5.
- A wake-up request held for several cycles without acknowledgement. A design that dropped or changed the request, or left on a stray `wake_ack`, would reach state 1 early or leave it wrongly.
- Exactly two frame pulses in state 2. An off-by-one counter would reach state 3 one pulse early or late.
- A partial clear of the control bits, which must not disable the block.
- A clear of all three control bits while in states 2 and 5. A design that ignored this would stay in the transition.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

  typedef enum logic [2:0] {
    SR_OFF   = 3'd0,
    SR_IDLE  = 3'd1,
    SR_ENTER = 3'd2,
    SR_ACT   = 3'd3,
    SR_SFU   = 3'd4,
    SR_EXIT  = 3'd5
  } sr_state_e;

  function automatic logic sr_is_active(input sr_state_e s);
    return (s == SR_ACT) || (s == SR_SFU);
  endfunction

  function automatic logic sr_is_transit(input sr_state_e s);
    return (s == SR_ENTER) || (s == SR_EXIT);
  endfunction

endpackage

// File: rtl/sr_frame_timer.sv
// Counts frame-start pulses while the static frame is being sent.
module sr_frame_timer #(
  parameter int FRAMES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic frame_start,
  output logic done
);
  localparam int CNT_W = (FRAMES < 2) ? 1 : $clog2(FRAMES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAMES - 1);

  logic [CNT_W-1:0] cnt;

  assign done = run && frame_start && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (frame_start && !done) begin
      cnt <= cnt + 1'b1;
    end
  end

  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= LAST));

endmodule

// File: rtl/sr_sfu_flag.sv
// Pending single-frame-update request; clears itself once consumed.
module sr_sfu_flag (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic set,
  input  logic consume,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pending <= 1'b0;
    end else if (set) begin
      pending <= 1'b1;
    end else if (consume) begin
      pending <= 1'b0;
    end
  end

  p_sfu_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (pending && !flush && !consume) |=> pending);

endmodule

// File: rtl/sr_wake_port.sv
// Valid/ready source for the sink wake-up write.
module sr_wake_port #(
  parameter int              ADDR_W    = 20,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] WAKE_ADDR = 20'h00600,
  parameter logic [DATA_W-1:0] WAKE_DATA = 8'h01
) (
  input  logic              want,
  input  logic              ack,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              done
);
  always_comb begin
    req  = want;
    addr = want ? WAKE_ADDR : '0;
    data = want ? WAKE_DATA : '0;
    done = want && ack;
  end
endmodule

// File: rtl/selfrefresh_sequencer.sv
module selfrefresh_sequencer
  import sr_seq_pkg::*;
#(
  parameter int MODE_W        = 2,
  parameter int STATIC_FRAMES = 2,
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_enable,
  input  logic [MODE_W-1:0] ctl_mode,
  input  logic              ctl_entry,
  input  logic              ctl_sfu_set,
  input  logic              frame_start,
  input  logic              wake_ack,
  output logic              wake_req,
  output logic [ADDR_W-1:0] wake_addr,
  output logic [DATA_W-1:0] wake_data,
  output logic [2:0]        state_o,
  output logic              in_trans,
  output logic              sr_active,
  output logic              sfu_pending
);
  localparam logic [ADDR_W-1:0] SINK_POWER_ADDR = ADDR_W'(32'h600);
  localparam logic [DATA_W-1:0] SINK_WAKE_VAL   = DATA_W'(8'h01);

  sr_state_e state, nxt;
  logic      disable_all;
  logic      timer_done;
  logic      wake_done;
  logic      sfu_consume;

  assign disable_all = !ctl_enable && (ctl_mode == '0) && !ctl_entry;
  assign sfu_consume = (state == SR_SFU) && frame_start && !disable_all;

  sr_frame_timer #(.FRAMES(STATIC_FRAMES)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .run         (state == SR_ENTER),
    .frame_start (frame_start),
    .done        (timer_done)
  );

  sr_sfu_flag u_sfu (
    .clk     (clk),
    .rst     (rst),
    .flush   (disable_all || (state == SR_OFF)),
    .set     (ctl_sfu_set),
    .consume (sfu_consume),
    .pending (sfu_pending)
  );

  sr_wake_port #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .WAKE_ADDR (SINK_POWER_ADDR),
    .WAKE_DATA (SINK_WAKE_VAL)
  ) u_wake (
    .want (state == SR_EXIT),
    .ack  (wake_ack),
    .req  (wake_req),
    .addr (wake_addr),
    .data (wake_data),
    .done (wake_done)
  );

  always_comb begin
    nxt = state;
    if (disable_all) begin
      nxt = SR_OFF;
    end else begin
      unique case (state)
        SR_OFF:   if (ctl_enable && (ctl_mode != '0)) nxt = SR_IDLE;
        SR_IDLE:  if (ctl_entry) nxt = SR_ENTER;
        SR_ENTER: if (timer_done) nxt = SR_ACT;
        SR_ACT: begin
          if (!ctl_entry)       nxt = SR_EXIT;
          else if (sfu_pending) nxt = SR_SFU;
        end
        SR_SFU:   if (frame_start) nxt = SR_ACT;
        SR_EXIT:  if (wake_done) nxt = SR_IDLE;
        default:  nxt = SR_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SR_OFF;
    else     state <= nxt;
  end

  assign state_o   = state;
  assign in_trans  = sr_is_transit(state);
  assign sr_active = sr_is_active(state);

  p_leave_off_r2: assert property (@(posedge clk) disable iff (rst)
    (state == SR_OFF) |=> (state == SR_OFF || state == SR_IDLE));

  p_idle_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (state == SR_IDLE && ctl_entry && !disable_all) |=> (state == SR_ENTER));

  p_skip_single_r5: assert property (@(posedge clk) disable iff (rst)
    (state == SR_ACT && !ctl_entry && !disable_all) |=> (state == SR_EXIT));

  p_wake_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (wake_req && !wake_ack && !disable_all) |=>
      (wake_req && $stable(wake_addr) && $stable(wake_data)));

  p_disable_r8: assert property (@(posedge clk) disable iff (rst)
    disable_all |=> (state == SR_OFF && !sfu_pending));

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
    sr_active |-> !in_trans);

endmodule

// File: tb/selfrefresh_sequencer_test.sv
module selfrefresh_sequencer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0, ent = 1'b0, sfu = 1'b0, frm = 1'b0, ack = 1'b0;
  logic [1:0] md = 2'd0;
  logic       wreq, intr, act, pend;
  logic [19:0] waddr;
  logic [7:0]  wdata;
  logic [2:0]  st;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] e;
  string      t;
  logic [2:0] es;
  logic [4:0] got, want;

  always #(CLK_PERIOD/2) clk = ~clk;

  selfrefresh_sequencer uut (
    .clk(clk), .rst(rst), .ctl_enable(en), .ctl_mode(md), .ctl_entry(ent),
    .ctl_sfu_set(sfu), .frame_start(frm), .wake_ack(ack), .wake_req(wreq),
    .wake_addr(waddr), .wake_data(wdata), .state_o(st), .in_trans(intr),
    .sr_active(act), .sfu_pending(pend)
  );

  task automatic step(input logic r, input logic e_en, input logic [1:0] e_md,
                      input logic e_ent, input logic e_sfu, input logic e_frm,
                      input logic e_ack, input int xs, input logic xsfu,
                      input string tag);
    @(negedge clk);
    rst = r; en = e_en; md = e_md; ent = e_ent; sfu = e_sfu; frm = e_frm; ack = e_ack;
    exp_q.push_back({3'(xs), xsfu});
    tag_q.push_back(tag);
  endtask

  // Monitor: compares each expected item just after the edge it belongs to.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      e  = exp_q.pop_front();
      t  = tag_q.pop_front();
      es = e[3:1];
      // R9: in_trans in 2,5; sr_active in 3,4; wake_req only in 5 (R7)
      want = {es, (es == 3'd2 || es == 3'd5), (es == 3'd3 || es == 3'd4)};
      got  = {st, intr, act};
      checks++;
      if (got !== want || pend !== e[0] || wreq !== (es == 3'd5)) begin
        errors++;
        $display("FAIL %s: state/trans/act/sfu/wreq got %0d/%b/%b/%b/%b exp %0d/%b/%b/%b/%b",
                 t, st, intr, act, pend, wreq, es, want[1], want[0], e[0], (es == 3'd5));
      end
      if (wreq) begin
        checks++;
        if (waddr !== 20'h00600 || wdata !== 8'h01) begin
          errors++;
          $display("FAIL R7 wake payload: got %h/%h exp 00600/01", waddr, wdata);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    //   rst en md ent sfu frm ack  exp  sfu
    step(1, 0, 0, 0, 0, 0, 0,  0, 0, "R1 reset");
    step(0, 1, 0, 0, 0, 0, 0,  0, 0, "R2 enable without mode");
    step(0, 0, 0, 1, 1, 0, 0,  0, 0, "R2 entry and sfu ignored in off");
    step(0, 0, 0, 0, 0, 0, 0,  0, 0, "R2 sfu still clear");
    step(0, 1, 1, 0, 0, 0, 0,  1, 0, "R2 enable with mode");
    step(0, 1, 1, 0, 0, 1, 0,  1, 0, "R3 frame ignored in idle");
    step(0, 1, 1, 1, 0, 0, 0,  2, 0, "R3 entry request");
    step(0, 1, 1, 1, 0, 0, 0,  2, 0, "R4 waiting");
    step(0, 1, 1, 1, 0, 1, 0,  2, 0, "R4 first frame");
    step(0, 1, 1, 1, 0, 0, 0,  2, 0, "R4 between frames");
    step(0, 1, 1, 1, 0, 1, 0,  3, 0, "R4 second frame");
    step(0, 1, 1, 1, 1, 0, 0,  3, 1, "R6 sfu set");
    step(0, 1, 1, 1, 0, 0, 0,  4, 1, "R6 enter single update");
    step(0, 1, 1, 0, 0, 0, 0,  4, 1, "R6 entry drop held in 4");
    step(0, 1, 1, 0, 0, 1, 0,  3, 0, "R6 frame returns, flag clears");
    step(0, 1, 1, 0, 0, 0, 0,  5, 0, "R5 exit");
    step(0, 1, 1, 0, 0, 0, 0,  5, 0, "R7 waiting for ack");
    step(0, 1, 1, 1, 0, 0, 0,  5, 0, "R7 entry ignored in exit");
    step(0, 1, 1, 0, 0, 0, 1,  1, 0, "R7 ack completes");
    step(0, 1, 1, 0, 1, 0, 0,  1, 1, "R6 sfu pending in idle");
    step(0, 1, 1, 1, 0, 0, 0,  2, 1, "R6 pending through enter");
    step(0, 1, 1, 1, 0, 1, 0,  2, 1, "R4 back-to-back frame one");
    step(0, 1, 1, 1, 0, 1, 0,  3, 1, "R4 back-to-back frame two");
    step(0, 1, 1, 1, 0, 0, 0,  4, 1, "R6 pending consumed in 3");
    step(0, 1, 1, 1, 0, 1, 0,  3, 0, "R6 return clears");
    step(0, 1, 1, 1, 1, 0, 0,  3, 1, "R6 set again");
    step(0, 1, 1, 0, 0, 0, 0,  5, 1, "R5 exit beats pending");
    step(0, 0, 0, 0, 0, 0, 0,  0, 0, "R8 disable during exit");
    step(0, 1, 1, 0, 0, 0, 0,  1, 0, "R2 re-enable");
    step(0, 0, 2, 0, 0, 0, 0,  1, 0, "R8 partial clear keeps idle");
    step(0, 0, 0, 1, 0, 0, 0,  2, 0, "R8 entry alone keeps enabled");
    step(0, 0, 0, 0, 0, 0, 0,  0, 0, "R8 disable during enter");
    step(0, 1, 1, 0, 0, 0, 1,  1, 0, "R7 stray ack off");
    step(0, 1, 1, 0, 0, 0, 1,  1, 0, "R7 stray ack idle");
    step(1, 1, 1, 1, 1, 0, 0,  0, 0, "R1 reset from idle");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule